// File: doc/BRIEF.md
# Borrow-Chained Subtract Flag Unit

This purely combinational unit forms the result and the status flags of the subtract operations that take part in a multi-byte borrow chain. It covers four operations. Two are byte subtracts with an incoming borrow, one using a register source and one using an immediate source. The third is a byte compare with an incoming borrow, which sets the flags and writes nothing. The fourth subtracts a 6-bit immediate from a 16-bit register pair. The surrounding core reads the operands from the register file, decodes the instruction into an operation select, and writes back the result and the flags the unit returns.

In a chain of byte operations the zero flag carries across bytes. A carry form can clear it but can never set it, so after the last byte it reports whether the whole multi-byte value was zero. The word form computes its flags from the complete 16-bit result. It also returns the register-file index of the low register of the pair it addresses, so the core can write both bytes back.

Top module: `sbc_flag_unit`

## Requirements
- R1: With op_sel = 0 (register subtract), res_lo equals (opd_lo - src_reg - carry_in) mod 256, res_hi is 0, wr_en is 1 and wr_word is 0.
- R2: With op_sel = 1 (immediate subtract), the second operand is src_imm instead of src_reg, and every other output follows R1 and R3 to R5.
- R3: For the byte forms, flag_c is 1 exactly when the subtraction borrows out of bit 7. flag_h is 1 exactly when the low nibble subtraction, including carry_in, borrows out of bit 3. h_upd is 1.
- R4: For the byte forms, flag_v is 1 exactly when the signed 8-bit difference lies outside -128..127. flag_n equals bit 7 of the result and flag_s equals flag_n xor flag_v.
- R5: For the byte forms, flag_z is 0 when the 8-bit result is nonzero and equals zero_in when it is zero.
- R6: With op_sel = 2 (compare), res_lo and every flag are the same as for op_sel = 0, and wr_en and wr_word are both 0.
- R7: With op_sel = 3 (word subtract), {res_hi,res_lo} equals ({opd_hi,opd_lo} - src_imm[5:0]) mod 65536, wr_en and wr_word are 1, flag_z is 1 exactly when the 16-bit result is zero, and flag_n is bit 15 of the result.
- R8: For the word form, flag_c is 1 exactly when the 16-bit subtraction borrows, flag_v is 1 exactly when the signed 16-bit difference falls below -32768, and flag_s equals flag_n xor flag_v.
- R9: For the word form, pair_idx equals 24 + 2 * pair_sel, flag_h and h_upd are 0, and carry_in and zero_in have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 register subtract, 1 immediate subtract, 2 compare, 3 word subtract |
| opd_lo | input | 8 | Destination byte, or low byte of the pair |
| opd_hi | input | 8 | High byte of the pair (word form only) |
| src_reg | input | 8 | Register source byte |
| src_imm | input | 8 | Immediate source; its low 6 bits are used by the word form |
| pair_sel | input | 2 | Register-pair field of the word form |
| carry_in | input | 1 | Incoming borrow |
| zero_in | input | 1 | Previous zero flag |
| res_lo | output | 8 | Result, low byte |
| res_hi | output | 8 | Result high byte (word form), else 0 |
| wr_en | output | 1 | Result is to be written back |
| wr_word | output | 1 | Write-back covers both bytes of the pair |
| pair_idx | output | 5 | Register index of the low register of the pair |
| flag_c | output | 1 | Borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_h | output | 1 | Half borrow flag |
| h_upd | output | 1 | flag_h is meaningful for this operation |

## Verification
The embedded assertions re-check relations on every input combination. They confirm that the zero flag never rises for a carry form when zero_in is low, that the compare raises no write, that the sign flag agrees with N and V, that a pair index is always even and inside the pair window, and that subtracting nothing never borrows. The arithmetic correctness of the result, the borrow, the half-borrow and the overflow flags cannot be seen from such local relations. The bench shows it by sweeping operand values exhaustively or near-exhaustively and comparing each output against plain integer arithmetic. The bench also shows that the word form ignores the carry and zero inputs.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned IMM_W     = 6;
    localparam int unsigned PAIR_W    = 2;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned PAIR_BASE = 24;

    typedef enum logic [1:0] {
        OP_SUB_REG = 2'd0,
        OP_SUB_IMM = 2'd1,
        OP_CMP     = 2'd2,
        OP_SUB_WRD = 2'd3
    } sub_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic s;
        logic h;
    } flags_t;

    function automatic logic is_byte_form(sub_op_e op);
        return op != OP_SUB_WRD;
    endfunction

    function automatic logic writes_back(sub_op_e op);
        return op != OP_CMP;
    endfunction

endpackage

// File: rtl/sbc_byte_path.sv
module sbc_byte_path
    import sbc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] r,
    input  logic         cin,
    input  logic         zin,
    output logic [W-1:0] res,
    output flags_t       fl
);
    localparam int unsigned MSB = W - 1;
    localparam int unsigned HB  = W / 2 - 1;

    logic dm, rm, qm, dh, rh, qh;

    always_comb begin
        res = d - r - {{(W-1){1'b0}}, cin};
        dm = d[MSB];
        rm = r[MSB];
        qm = res[MSB];
        dh = d[HB];
        rh = r[HB];
        qh = res[HB];
        fl.c = (~dm & rm) | (rm & qm) | (qm & ~dm);
        fl.h = (~dh & rh) | (rh & qh) | (qh & ~dh);
        fl.v = (dm & ~rm & ~qm) | (~dm & rm & qm);
        fl.n = qm;
        fl.s = qm ^ fl.v;
        fl.z = (res == '0) ? zin : 1'b0;
    end

    always_comb begin
        if (!cin && r == '0)
            assert_no_borrow_on_zero_R3: assert (!fl.c && !fl.h && res == d)
                else $error("subtracting zero produced a borrow");
    end
endmodule

// File: rtl/sbc_word_path.sv
module sbc_word_path
    import sbc_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 6
) (
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   hi,
    input  logic [IW-1:0]  imm,
    output logic [2*W-1:0] res,
    output flags_t         fl
);
    localparam int unsigned WW  = 2 * W;
    localparam int unsigned TOP = WW - 1;

    logic hm, qm;

    always_comb begin
        res = {hi, lo} - {{(WW-IW){1'b0}}, imm};
        hm = hi[W-1];
        qm = res[TOP];
        fl.v = ~qm & hm;
        fl.c = qm & ~hm;
        fl.n = qm;
        fl.s = qm ^ fl.v;
        fl.z = (res == '0);
        fl.h = 1'b0;
    end

    always_comb begin
        assert_word_flags_exclusive_R8: assert (!(fl.c && fl.v))
            else $error("word borrow and overflow both set");
    end
endmodule

// File: rtl/sbc_pair_index.sv
module sbc_pair_index #(
    parameter int unsigned PW   = 2,
    parameter int unsigned IDXW = 5,
    parameter int unsigned BASE = 24
) (
    input  logic [PW-1:0]   sel,
    output logic [IDXW-1:0] idx
);
    localparam logic [IDXW-1:0] BASE_V = IDXW'(BASE);

    always_comb begin
        idx = BASE_V + {{(IDXW-PW-1){1'b0}}, sel, 1'b0};
    end
endmodule

// File: rtl/sbc_flag_unit.sv
module sbc_flag_unit
    import sbc_pkg::*;
(
    input  logic [1:0] op_sel,
    input  logic [7:0] opd_lo,
    input  logic [7:0] opd_hi,
    input  logic [7:0] src_reg,
    input  logic [7:0] src_imm,
    input  logic [1:0] pair_sel,
    input  logic       carry_in,
    input  logic       zero_in,
    output logic [7:0] res_lo,
    output logic [7:0] res_hi,
    output logic       wr_en,
    output logic       wr_word,
    output logic [4:0] pair_idx,
    output logic       flag_c,
    output logic       flag_z,
    output logic       flag_n,
    output logic       flag_v,
    output logic       flag_s,
    output logic       flag_h,
    output logic       h_upd
);
    localparam int unsigned WW = 2 * DATA_W;

    sub_op_e           op;
    logic [DATA_W-1:0] byte_src;
    logic [DATA_W-1:0] byte_res;
    logic [WW-1:0]     word_res;
    flags_t            byte_fl, word_fl, sel_fl;

    assign op = sub_op_e'(op_sel);

    always_comb begin
        byte_src = (op == OP_SUB_IMM) ? src_imm : src_reg;
    end

    sbc_byte_path #(.W(DATA_W)) byte_i (
        .d   (opd_lo),
        .r   (byte_src),
        .cin (carry_in),
        .zin (zero_in),
        .res (byte_res),
        .fl  (byte_fl)
    );

    sbc_word_path #(.W(DATA_W), .IW(IMM_W)) word_i (
        .lo  (opd_lo),
        .hi  (opd_hi),
        .imm (src_imm[IMM_W-1:0]),
        .res (word_res),
        .fl  (word_fl)
    );

    sbc_pair_index #(.PW(PAIR_W), .IDXW(REG_IDX_W), .BASE(PAIR_BASE)) pidx_i (
        .sel (pair_sel),
        .idx (pair_idx)
    );

    always_comb begin
        if (is_byte_form(op)) begin
            sel_fl  = byte_fl;
            res_lo  = byte_res;
            res_hi  = '0;
            wr_word = 1'b0;
            h_upd   = 1'b1;
        end else begin
            sel_fl  = word_fl;
            res_lo  = word_res[DATA_W-1:0];
            res_hi  = word_res[WW-1:DATA_W];
            wr_word = 1'b1;
            h_upd   = 1'b0;
        end
        wr_en  = writes_back(op);
        flag_c = sel_fl.c;
        flag_z = sel_fl.z;
        flag_n = sel_fl.n;
        flag_v = sel_fl.v;
        flag_s = sel_fl.s;
        flag_h = sel_fl.h;
    end

    always_comb begin
        if (op != OP_SUB_WRD && !zero_in)
            assert_zero_sticky_R5: assert (!flag_z)
                else $error("zero flag raised by a carry form");
        if (op == OP_CMP)
            assert_compare_no_write_R6: assert (!wr_en && !wr_word)
                else $error("compare requested a write");
        assert_sign_rule_R4: assert (flag_s == (flag_n ^ flag_v))
            else $error("sign flag inconsistent");
        if (op == OP_SUB_WRD)
            assert_pair_window_R9: assert (!pair_idx[0] && pair_idx >= 5'(PAIR_BASE) && !h_upd)
                else $error("pair index outside window");
    end
endmodule

// File: tb/sbc_flag_unit_tb.sv
module sbc_flag_unit_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0] op_sel = '0;
    logic [7:0] opd_lo = '0, opd_hi = '0, src_reg = '0, src_imm = '0;
    logic [1:0] pair_sel = '0;
    logic       carry_in = 1'b0, zero_in = 1'b0;
    logic [7:0] res_lo, res_hi;
    logic       wr_en, wr_word, flag_c, flag_z, flag_n, flag_v, flag_s, flag_h, h_upd;
    logic [4:0] pair_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    sbc_flag_unit dut_i (
        .op_sel, .opd_lo, .opd_hi, .src_reg, .src_imm, .pair_sel,
        .carry_in, .zero_in, .res_lo, .res_hi, .wr_en, .wr_word, .pair_idx,
        .flag_c, .flag_z, .flag_n, .flag_v, .flag_s, .flag_h, .h_upd
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h (op=%0d d=%0h hi=%0h r=%0h i=%0h c=%0b z=%0b)",
                     req, what, got, exp, op_sel, opd_lo, opd_hi, src_reg, src_imm, carry_in, zero_in);
        end
    endtask

    // byte forms: op 0,1,2
    task automatic run_byte(input int op, input int d, input int r, input int imm,
                            input int ci, input int zi);
        int rs, diff, er, hd, sd, ss, sdf, ev, en;
        op_sel = 2'(op); opd_lo = 8'(d); src_reg = 8'(r); src_imm = 8'(imm);
        carry_in = 1'(ci); zero_in = 1'(zi);
        opd_hi = 8'(d ^ 8'h5a); pair_sel = 2'(d);
        #1;
        rs   = (op == 1) ? imm : r;
        diff = d - rs - ci;
        er   = diff & 255;
        hd   = (d & 15) - (rs & 15) - ci;
        sd   = (d >= 128) ? d - 256 : d;
        ss   = (rs >= 128) ? rs - 256 : rs;
        sdf  = sd - ss - ci;
        ev   = (sdf < -128 || sdf > 127) ? 1 : 0;
        en   = (er >> 7) & 1;
        chk(op == 1 ? "R2" : (op == 2 ? "R6" : "R1"), "result", int'(res_lo), er);
        chk("R1", "res_hi", int'(res_hi), 0);
        chk("R3", "C", int'(flag_c), diff < 0 ? 1 : 0);
        chk("R3", "H", int'(flag_h), hd < 0 ? 1 : 0);
        chk("R3", "h_upd", int'(h_upd), 1);
        chk("R4", "V", int'(flag_v), ev);
        chk("R4", "N", int'(flag_n), en);
        chk("R4", "S", int'(flag_s), en ^ ev);
        chk("R5", "Z", int'(flag_z), er == 0 ? zi : 0);
        chk(op == 2 ? "R6" : "R1", "wr_en", int'(wr_en), op == 2 ? 0 : 1);
        chk("R6", "wr_word", int'(wr_word), 0);
    endtask

    task automatic run_word(input int hi, input int lo, input int imm, input int ps,
                            input int ci, input int zi);
        int full, diff, er, sf, sdf, ev, en;
        op_sel = 2'd3; opd_lo = 8'(lo); opd_hi = 8'(hi); src_imm = 8'(imm | 8'hc0);
        src_reg = 8'(~lo); pair_sel = 2'(ps); carry_in = 1'(ci); zero_in = 1'(zi);
        #1;
        full = hi * 256 + lo;
        diff = full - imm;
        er   = diff & 65535;
        sf   = (full >= 32768) ? full - 65536 : full;
        sdf  = sf - imm;
        ev   = (sdf < -32768) ? 1 : 0;
        en   = (er >> 15) & 1;
        chk("R7", "word result", int'({res_hi, res_lo}), er);
        chk("R7", "wr_en", int'(wr_en), 1);
        chk("R7", "wr_word", int'(wr_word), 1);
        chk("R7", "Z", int'(flag_z), er == 0 ? 1 : 0);
        chk("R7", "N", int'(flag_n), en);
        chk("R8", "C", int'(flag_c), diff < 0 ? 1 : 0);
        chk("R8", "V", int'(flag_v), ev);
        chk("R8", "S", int'(flag_s), en ^ ev);
        chk("R9", "pair_idx", int'(pair_idx), 24 + 2 * ps);
        chk("R9", "H", int'(flag_h), 0);
        chk("R9", "h_upd", int'(h_upd), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #1;
        // idle inputs: 0 - 0 - 0 with zero_in low
        chk("R5", "idle Z", int'(flag_z), 0);
        chk("R1", "idle result", int'(res_lo), 0);
        // R1, R3, R4, R5: full register subtract sweep
        for (int d = 0; d < 256; d++)
            for (int r = 0; r < 256; r++)
                for (int c = 0; c < 2; c++)
                    run_byte(0, d, r, 8'h33, c, (d ^ r ^ c) & 1);
        // zero result with both zero_in values (R5 sticky chain)
        run_byte(0, 8'h10, 8'h0f, 0, 1, 1);
        run_byte(0, 8'h10, 8'h0f, 0, 1, 0);
        // R2: immediate subtract, src_reg deliberately different
        for (int d = 0; d < 256; d++)
            for (int k = 0; k < 256; k += 5)
                for (int c = 0; c < 2; c++)
                    run_byte(1, d, k ^ 8'hff, k, c, 1);
        // R6: compare
        for (int d = 0; d < 256; d++)
            for (int r = 0; r < 256; r += 7)
                for (int c = 0; c < 2; c++)
                    run_byte(2, d, r, 0, c, 1 - c);
        run_byte(2, 8'h80, 8'h80, 0, 0, 1);
        // R7, R8, R9: word subtract
        for (int h = 0; h < 6; h++)
            for (int lo = 0; lo < 256; lo += 3)
                for (int k = 0; k < 64; k++) begin
                    int hv;
                    hv = (h == 0) ? 8'h00 : (h == 1) ? 8'h01 : (h == 2) ? 8'h7f :
                         (h == 3) ? 8'h80 : (h == 4) ? 8'hff : 8'h3c;
                    run_word(hv, lo, k, (lo + k) & 3, k & 1, (k >> 1) & 1);
                end
        // word boundary corners, carry/zero inputs toggled (R9)
        run_word(8'h00, 8'h00, 0, 0, 1, 0);
        run_word(8'h00, 8'h00, 1, 3, 0, 1);
        run_word(8'h80, 8'h00, 1, 2, 1, 1);
        run_word(8'h80, 8'h3f, 63, 1, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule